// File: doc/BRIEF.md
# Bit Permutation and Count Unit

This unit performs single-operand bit manipulation on a data word. An opcode selects the operation. Most operations use only the primary operand. Left rotate takes its amount from the auxiliary operand, and the leftmost-bit search takes its target polarity from the auxiliary operand.

The available operations are:
- per-byte population count
- full bit reversal
- separation of even and odd bits into two halfwords, and the reverse merge
- swapping the two bytes inside each halfword
- building a lane mask from the lowest source bits
- left rotate
- counting the bits that lie above the first match when scanning from the top

Each accepted request takes one cycle. The result is held in a register and marked with a valid flag. When no request arrives, the result register keeps its last value. The default configuration is a 32-bit word.

Top module: `bitperm_unit`

## Requirements
- R1: Opcode 0 (byte count): each result byte holds the number of set bits of the source byte at the same position.
- R2: Opcode 1 (reverse): source bit i appears at result bit 31-i, for every i.
- R3: Opcode 2 (split): source bits 0,2,4,…,30 go in order to result bits 0..15, and source bits 1,3,…,31 go in order to result bits 16..31.
- R4: Opcode 3 (merge): source bit i (i<16) goes to result bit 2i and source bit 16+i goes to result bit 2i+1. Merge applied to the output of split returns the original word.
- R5: Opcode 4 (halfword byte swap): result bits 7:0 and 15:8 exchange, and result bits 23:16 and 31:24 exchange.
- R6: Opcode 5 (two-lane mask): result bits 31:16 all equal source bit 1 and bits 15:0 all equal source bit 0. Source bits 31:2 have no effect.
- R7: Opcode 6 (four-lane mask): result byte k is all copies of source bit k, where byte 0 is bits 7:0. Source bits 31:4 have no effect.
- R8: Opcode 7 (rotate left): the source is rotated left by the value of auxiliary bits 4:0. Auxiliary bits 31:5 have no effect.
- R9: Opcode 8 (leftmost search): the search target is a 1 when auxiliary bit 0 is 1 and a 0 otherwise. The result is the number of bits above the highest matching bit, or 32 if no bit matches.
- R10: A request accepted with in_valid at a clock edge appears on out_result with out_valid high after that edge. While in_valid is low, out_valid is low after the edge and out_result keeps its value.
- R11: While rst is high, out_valid and out_result are 0 after each clock edge.
- R12: Opcodes 9 through 15 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation select |
| in_src | input | 32 | Primary operand |
| in_aux | input | 32 | Rotate amount or search polarity |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 32 | Registered result |

## Verification
Several corner cases are targeted directly:

- **Leftmost search.** The bench searches all-zero, all-one, single top-bit and single bottom-bit words for both polarities. A design that sends the no-match case to 31 or 0, or that counts from the wrong end, fails these checks.
- **Rotate.** All 32 rotate amounts are used, with junk in the upper auxiliary bits. This exposes an amount decoder that is too wide, and a zero rotate that clears the word.
- **Lane masks.** Every value of the low four source bits is applied with random upper bits. This catches a lane order that is reversed, and upper bits that leak into the mask.
- **Split and merge.** Split and merge are run back to back on the same words. An even/odd swap, or a halfword placed on the wrong side, then shows up as a round-trip mismatch.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_BYTECOUNT = 4'd0,
    OP_REVERSE   = 4'd1,
    OP_SPLIT     = 4'd2,
    OP_MERGE     = 4'd3,
    OP_HSWAP     = 4'd4,
    OP_MASK2     = 4'd5,
    OP_MASK4     = 4'd6,
    OP_ROTL      = 4'd7,
    OP_LEFTMOST  = 4'd8
  } bp_op_e;
endpackage

// File: rtl/bitperm_count.sv
module bitperm_count #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic              want_one,
  output logic [DATA_W-1:0] bytecount,
  output logic [DATA_W-1:0] leftmost
);
  localparam int NBYTE = DATA_W / 8;
  localparam int CW    = $clog2(DATA_W + 1);

  genvar b;
  generate
    for (b = 0; b < NBYTE; b++) begin : g_byte
      logic [3:0] cnt;
      always_comb begin
        cnt = 4'd0;
        for (int j = 0; j < 8; j++) cnt = cnt + {3'b000, src[8*b+j]};
      end
      assign bytecount[8*b +: 8] = {4'b0000, cnt};
      always_comb begin
        assert (cnt <= 4'd8) else $error("assert_bytecount_range_R1");
      end
    end
  endgenerate

  logic [CW-1:0] lm_cnt;
  logic          lm_hit;
  always_comb begin
    lm_cnt = CW'(DATA_W);
    lm_hit = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!lm_hit && (src[i] == want_one)) begin
        lm_cnt = CW'(DATA_W - 1 - i);
        lm_hit = 1'b1;
      end
    end
  end
  assign leftmost = {{(DATA_W-CW){1'b0}}, lm_cnt};

  always_comb begin
    assert (lm_cnt <= CW'(DATA_W)) else $error("assert_search_range_R9");
    assert (lm_hit || (lm_cnt == CW'(DATA_W))) else $error("assert_search_nomatch_R9");
  end
endmodule

// File: rtl/bitperm_shuffle.sv
module bitperm_shuffle #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] reversed,
  output logic [DATA_W-1:0] split,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] hswap
);
  localparam int HALF  = DATA_W / 2;
  localparam int NHALF = DATA_W / 16;

  logic [DATA_W-1:0] remerge;

  genvar i, h;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_rev
      assign reversed[DATA_W-1-i] = src[i];
    end
    for (i = 0; i < HALF; i++) begin : g_pair
      assign split[i]          = src[2*i];
      assign split[HALF+i]     = src[2*i+1];
      assign merged[2*i]       = src[i];
      assign merged[2*i+1]     = src[HALF+i];
      assign remerge[2*i]      = split[i];
      assign remerge[2*i+1]    = split[HALF+i];
    end
    for (h = 0; h < NHALF; h++) begin : g_hw
      assign hswap[16*h +: 8]   = src[16*h+8 +: 8];
      assign hswap[16*h+8 +: 8] = src[16*h +: 8];
    end
  endgenerate

  always_comb begin
    assert (remerge == src) else $error("assert_split_merge_inverse_R4");
  end
endmodule

// File: rtl/bitperm_mask.sv
module bitperm_mask #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] mask2,
  output logic [DATA_W-1:0] mask4,
  output logic [DATA_W-1:0] rotl
);
  localparam int HALF  = DATA_W / 2;
  localparam int NBYTE = DATA_W / 8;
  localparam int SHW   = $clog2(DATA_W);

  assign mask2 = {{HALF{src[1]}}, {HALF{src[0]}}};

  genvar k;
  generate
    for (k = 0; k < NBYTE; k++) begin : g_lane
      assign mask4[8*k +: 8] = {8{src[k]}};
      always_comb begin
        assert ((mask4[8*k +: 8] == 8'h00) || (mask4[8*k +: 8] == 8'hFF))
          else $error("assert_lane_uniform_R7");
      end
    end
  endgenerate

  logic [SHW-1:0]      amt;
  logic [2*DATA_W-1:0] dbl;
  assign amt  = aux[SHW-1:0];
  assign dbl  = {src, src} << amt;
  assign rotl = dbl[2*DATA_W-1:DATA_W];

  always_comb begin
    assert ($countones(rotl) == $countones(src)) else $error("assert_rotate_weight_R8");
  end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     in_op,
  input  logic [DATA_W-1:0]   in_src,
  input  logic [DATA_W-1:0]   in_aux,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result
);
  logic [DATA_W-1:0] r_count, r_left, r_rev, r_split, r_merge, r_swap;
  logic [DATA_W-1:0] r_m2, r_m4, r_rot;
  logic [DATA_W-1:0] sel;

  bitperm_count #(.DATA_W(DATA_W)) u_count (
    .src(in_src), .want_one(in_aux[0]),
    .bytecount(r_count), .leftmost(r_left)
  );

  bitperm_shuffle #(.DATA_W(DATA_W)) u_shuffle (
    .src(in_src), .reversed(r_rev), .split(r_split),
    .merged(r_merge), .hswap(r_swap)
  );

  bitperm_mask #(.DATA_W(DATA_W)) u_mask (
    .src(in_src), .aux(in_aux),
    .mask2(r_m2), .mask4(r_m4), .rotl(r_rot)
  );

  always_comb begin
    case (bp_op_e'(in_op))
      OP_BYTECOUNT: sel = r_count;
      OP_REVERSE:   sel = r_rev;
      OP_SPLIT:     sel = r_split;
      OP_MERGE:     sel = r_merge;
      OP_HSWAP:     sel = r_swap;
      OP_MASK2:     sel = r_m2;
      OP_MASK4:     sel = r_m4;
      OP_ROTL:      sel = r_rot;
      OP_LEFTMOST:  sel = r_left;
      default:      sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= sel;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_result == '0)));
endmodule

// File: tb/bitperm_unit_tb.sv
module bitperm_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [31:0] in_src, in_aux;
  logic        out_valid;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  bitperm_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_aux(in_aux),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [31:0] nextrand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic rnd(output logic [31:0] v);
    seed = nextrand(seed);
    v = seed;
  endtask

  function automatic logic [31:0] ref_pop(input logic [31:0] x);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] v = x[8*b +: 8];
      int n = 0;
      while (v != 0) begin v = v & (v - 8'd1); n++; end
      r[8*b +: 8] = 8'(n);
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_rev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = x[i];
    return r;
  endfunction

  function automatic logic [31:0] ref_split(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin r[i] = x[2*i]; r[16+i] = x[2*i+1]; end
    return r;
  endfunction

  function automatic logic [31:0] ref_merge(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i % 2 == 0) ? x[i/2] : x[16 + i/2];
    return r;
  endfunction

  function automatic logic [31:0] ref_swap(input logic [31:0] x);
    return ((x & 32'h00FF_00FF) << 8) | ((x >> 8) & 32'h00FF_00FF);
  endfunction

  function automatic logic [31:0] ref_m2(input logic [31:0] x);
    return (x[1] ? 32'hFFFF_0000 : 32'h0) | (x[0] ? 32'h0000_FFFF : 32'h0);
  endfunction

  function automatic logic [31:0] ref_m4(input logic [31:0] x);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (x[k]) r = r | (32'hFF << (8*k));
    return r;
  endfunction

  function automatic logic [31:0] ref_rotl(input logic [31:0] x, input logic [31:0] a);
    logic [31:0] r = x;
    for (int n = 0; n < int'(a % 32); n++) r = {r[30:0], r[31]};
    return r;
  endfunction

  function automatic logic [31:0] ref_left(input logic [31:0] x, input logic [31:0] a);
    int n = 0;
    while (n < 32 && x[31-n] != a[0]) n++;
    return 32'(n);
  endfunction

  function automatic logic [31:0] ref_any(input logic [3:0] op, input logic [31:0] x,
                                          input logic [31:0] a);
    case (op)
      4'd0: return ref_pop(x);
      4'd1: return ref_rev(x);
      4'd2: return ref_split(x);
      4'd3: return ref_merge(x);
      4'd4: return ref_swap(x);
      4'd5: return ref_m2(x);
      4'd6: return ref_m4(x);
      4'd7: return ref_rotl(x, a);
      4'd8: return ref_left(x, a);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] x, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = x; in_aux = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input string req, input logic [3:0] op,
                     input logic [31:0] x, input logic [31:0] a);
    issue(op, x, a);
    check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    check(req, out_result, ref_any(op, x, a));
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R12";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, a, sv;
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_src = '0; in_aux = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid", {31'h0, out_valid}, 32'h0);
    check("R11 result", out_result, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Sweep every opcode, including the undefined ones (R12)
    for (int op = 0; op < 16; op++) begin
      for (int n = 0; n < 40; n++) begin
        rnd(x); rnd(a);
        run(tag_of(4'(op)), 4'(op), x, a);
      end
      run(tag_of(4'(op)), 4'(op), 32'h0, 32'h0);
      run(tag_of(4'(op)), 4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    end

    // R9: search boundaries, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      run("R9", 4'd8, 32'h0000_0000, 32'(pol));
      run("R9", 4'd8, 32'hFFFF_FFFF, 32'(pol));
      run("R9", 4'd8, 32'h8000_0000, 32'(pol) | 32'hFFFF_FFFE);
      run("R9", 4'd8, 32'h0000_0001, 32'(pol));
      run("R9", 4'd8, 32'h7FFF_FFFF, 32'(pol));
      run("R9", 4'd8, 32'hFFFF_FFFE, 32'(pol) | 32'h5A5A_5A5A);
    end

    // R8: all rotate amounts with junk above bit 4
    for (int s = 0; s < 32; s++) begin
      rnd(x); rnd(a);
      run("R8", 4'd7, x, (a & 32'hFFFF_FFE0) | 32'(s));
    end

    // R6, R7: every low nibble with random upper source bits
    for (int v = 0; v < 16; v++) begin
      rnd(x);
      run("R6", 4'd5, (x & 32'hFFFF_FFF0) | 32'(v), 32'h0);
      run("R7", 4'd6, (x & 32'hFFFF_FFF0) | 32'(v), 32'h0);
    end

    // R1 / R5 patterned words
    run("R1", 4'd0, 32'h0180_7FFF, 32'h0);
    run("R5", 4'd4, 32'h1122_3344, 32'h0);
    run("R2", 4'd1, 32'h0000_0001, 32'h0);

    // R3 then R4: round trip through the ports
    for (int n = 0; n < 30; n++) begin
      rnd(x);
      issue(4'd2, x, 32'h0);
      check("R3", out_result, ref_split(x));
      sv = out_result;
      issue(4'd3, sv, 32'h0);
      check("R4 round trip", out_result, x);
    end

    // R10: idle cycles keep the result and drop valid
    rnd(x);
    run("R10", 4'd1, x, 32'h0);
    sv = out_result;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      in_op = 4'd0; rnd(in_src); rnd(in_aux);
      @(negedge clk);
      check("R10 idle valid", {31'h0, out_valid}, 32'h0);
      check("R10 hold", out_result, sv);
    end

    // R11: reset mid-stream clears the output
    issue(4'd1, 32'h1, 32'h0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R11 valid", {31'h0, out_valid}, 32'h0);
    check("R11 result", out_result, 32'h0);
    rst = 1'b0; in_valid = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule